// File: doc/BRIEF.md
# Error-Correcting Two-Clock Block RAM

This block is a synchronous word memory in which every 32-bit data word sits next to seven check bits: six Hamming check bits and one overall parity bit. Together they correct any single flipped bit and flag any two flipped bits. Writes enter on one clock and reads leave on another. Byte lanes of a write can be masked. When only some lanes are enabled and correction is on, the block reads the stored word, corrects it, merges the new lanes into it and re-encodes the result in the same cycle.

A read passes through a capture stage that is loaded only when the read enable is high. It then passes through an output register with its own clock enable and a synchronous clear. The corrected data and two error flags (repaired, unrepairable) come out of that register together. A control input switches correction off at runtime. Reads then return the raw stored bits and the flags stay low, so injected faults can be seen directly. A test port flips any single stored bit of any word.

A one-cycle clear request walks the array at one address per write clock and writes zero to each word. Write-port traffic is shut out for the whole sweep.

Top module: `ecc_bram`

## Requirements
- R1: Each stored word is 39 bits wide. Stored bit p-1 holds Hamming position p for p = 1..38. Check bits sit at the power-of-two positions. Data bit k fills the k-th non-power-of-two position in ascending order, so data bit 0 is stored bit 2, data bit 8 is stored bit 12 and data bit 31 is stored bit 37. Stored bit 38 makes the parity of all 39 bits even.
- R2: With `rd_en` high at read edge N and `out_ce` high at edge N+1, `rd_data` shows the word at `rd_addr` after edge N+1.
- R3: With `ecc_on` high, a word with exactly one flipped stored bit reads back as the originally written data with `err_corr`=1 and `err_uncorr`=0.
- R4: With `ecc_on` high, a word with two flipped stored bits reads with `err_uncorr`=1 and `err_corr`=0. The two flags are never high together.
- R5: With `ecc_on` low when a read is captured, `rd_data` is the raw stored data bits without correction, and both flags are 0.
- R6: While `rd_en` stays low, `rd_data` keeps its previous value, even if the addressed word is rewritten.
- R7: When `out_ce` is low, the output register holds its value. `out_srst` high clears `rd_data` and both flags to 0 at the next read edge, whatever the state of `out_ce`.
- R8: `wr_be[i]` set means data bits 8i+7..8i of the word are replaced. A cleared lane keeps its stored value.
- R9: A partial write with `ecc_on` high corrects a single-bit error in the stored word before merging. The word afterwards reads with no flags.
- R10: A `zero_go` pulse taken while idle sets `zero_busy` after that edge. `zero_busy` stays high for exactly DEPTH write cycles, and afterwards every word reads as 0 with no flags.
- R11: While `zero_busy` is high, writes, bit injections and further clear requests are ignored.
- R12: A read captured at a write edge after the write edge that stored a word returns the new data.
- R13: `inj_en` flips stored bit `inj_bit` of word `inj_addr` at the write edge. It is ignored in a cycle when `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port and clear-sequencer clock |
| rd_clk | input | 1 | Read-port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the clear sequencer |
| wr_en | input | 1 | Write request |
| wr_addr | input | 6 | Write word address |
| wr_be | input | 4 | Per-byte write mask |
| wr_data | input | 32 | Write data |
| ecc_on | input | 1 | Correction enable; low selects raw bypass |
| zero_go | input | 1 | Request a full-array clear |
| zero_busy | output | 1 | Clear sweep in progress |
| inj_en | input | 1 | Flip one stored bit (test) |
| inj_addr | input | 6 | Word address for the flip |
| inj_bit | input | 6 | Stored bit index 0..38 to flip |
| rd_en | input | 1 | Read capture enable |
| rd_addr | input | 6 | Read word address |
| out_ce | input | 1 | Output register clock enable |
| out_srst | input | 1 | Output register synchronous clear |
| rd_data | output | 32 | Registered read data |
| err_corr | output | 1 | Registered: single-bit error repaired |
| err_uncorr | output | 1 | Registered: double-bit error detected |

## Verification
The bench flips the overall parity bit and the highest data bit alone. A decoder that indexes the syndrome wrongly, or that treats a parity-only fault as clean, returns wrong data or a missing flag on those reads. A partial write over a word with a fault is checked next. A design that merges uncorrected bits keeps the fault in the word, or re-encodes it into silent corruption that a later read cannot see. The clear sweep is timed cycle by cycle and hit with writes and injections in mid-sweep. An off-by-one sweep, or a port that is not locked out, leaves a nonzero or flagged word. Holds on the read enable and the output enable are checked while the addressed word changes underneath, so a stage that reloads anyway shows the new value.

// File: rtl/ecc_bram_pkg.sv
package ecc_bram_pkg;

   // number of Hamming check bits needed to cover dw data bits
   function automatic int chk_bits(input int dw);
      int p;
      p = 1;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v & (v - 1)) == 0;
   endfunction

endpackage

// File: rtl/ecc_bram_enc.sv
module ecc_bram_enc
   import ecc_bram_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]                   din,
   output logic [DATA_W+chk_bits(DATA_W):0]    cw
);
   localparam int CHK_W = chk_bits(DATA_W);
   localparam int HAM_W = DATA_W + CHK_W;

   always_comb begin
      logic [HAM_W:1] h;
      logic           x;
      int             k;
      h = '0;
      k = 0;
      for (int p = 1; p <= HAM_W; p++) begin
         if (!is_pow2(p)) begin
            h[p] = din[k];
            k++;
         end
      end
      for (int i = 0; i < CHK_W; i++) begin
         x = 1'b0;
         for (int p = 1; p <= HAM_W; p++) begin
            if (p[i]) x = x ^ h[p];
         end
         h[1 << i] = x;
      end
      cw = {^h, h};
   end
endmodule

// File: rtl/ecc_bram_dec.sv
module ecc_bram_dec
   import ecc_bram_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W+chk_bits(DATA_W):0] cw,
   input  logic                             ecc_on,
   output logic [DATA_W-1:0]                dout,
   output logic                             corr,
   output logic                             uncorr
);
   localparam int CHK_W = chk_bits(DATA_W);
   localparam int HAM_W = DATA_W + CHK_W;

   always_comb begin
      logic [HAM_W:1]   h;
      logic [CHK_W-1:0] syn;
      logic             odd;
      int               k;
      h      = cw[HAM_W-1:0];
      odd    = ^cw;
      syn    = '0;
      corr   = 1'b0;
      uncorr = 1'b0;
      for (int i = 0; i < CHK_W; i++) begin
         for (int p = 1; p <= HAM_W; p++) begin
            if (p[i]) syn[i] = syn[i] ^ h[p];
         end
      end
      if (ecc_on) begin
         if (odd) begin
            if (syn == '0) begin
               corr = 1'b1;               // only the overall parity bit flipped
            end else if (int'(syn) <= HAM_W) begin
               h[int'(syn)] = ~h[int'(syn)];
               corr = 1'b1;
            end else begin
               uncorr = 1'b1;
            end
         end else if (syn != '0) begin
            uncorr = 1'b1;
         end
      end
      dout = '0;
      k    = 0;
      for (int p = 1; p <= HAM_W; p++) begin
         if (!is_pow2(p)) begin
            dout[k] = h[p];
            k++;
         end
      end
   end
endmodule

// File: rtl/ecc_bram_zero.sv
module ecc_bram_zero #(
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   output logic          busy,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         addr <= '0;
      end else if (!busy) begin
         if (go) begin
            busy <= 1'b1;
            addr <= '0;
         end
      end else if (addr == LAST) begin
         busy <= 1'b0;
      end else begin
         addr <= addr + 1'b1;
      end
   end
endmodule

// File: rtl/ecc_bram_array.sv
module ecc_bram_array
   import ecc_bram_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   parameter int AW     = 6,
   parameter int IBW    = 6
) (
   input  logic                            clk,
   input  logic                            wr_en,
   input  logic [AW-1:0]                   wr_addr,
   input  logic [DATA_W/8-1:0]             wr_be,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            ecc_on,
   input  logic                            zero_busy,
   input  logic [AW-1:0]                   zero_addr,
   input  logic                            inj_en,
   input  logic [AW-1:0]                   inj_addr,
   input  logic [IBW-1:0]                  inj_bit,
   input  logic [AW-1:0]                   rd_addr,
   output logic [DATA_W+chk_bits(DATA_W):0] rd_word
);
   localparam int CW_W = DATA_W + chk_bits(DATA_W) + 1;
   localparam int NB   = DATA_W / 8;

   logic [CW_W-1:0]   mem [DEPTH];
   logic [CW_W-1:0]   old_cw;
   logic [CW_W-1:0]   new_cw;
   logic [DATA_W-1:0] old_data;
   logic [DATA_W-1:0] merged;
   logic              old_corr;
   logic              old_uncorr;

   assign old_cw  = mem[wr_addr];
   assign rd_word = mem[rd_addr];

   // read side of the read-modify-write: corrected when ecc_on is high
   ecc_bram_dec #(.DATA_W(DATA_W)) u_old (
      .cw     (old_cw),
      .ecc_on (ecc_on),
      .dout   (old_data),
      .corr   (old_corr),
      .uncorr (old_uncorr)
   );

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : old_data[b*8 +: 8];
   end

   ecc_bram_enc #(.DATA_W(DATA_W)) u_new (
      .din (merged),
      .cw  (new_cw)
   );

   always_ff @(posedge clk) begin
      if (zero_busy) begin
         mem[zero_addr] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= new_cw;
      end else if (inj_en && (int'(inj_bit) < CW_W)) begin
         mem[inj_addr][inj_bit] <= ~mem[inj_addr][inj_bit];
      end
   end
endmodule

// File: rtl/ecc_bram_rdpath.sv
module ecc_bram_rdpath
   import ecc_bram_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                             clk,
   input  logic                             rd_en,
   input  logic                             ecc_on,
   input  logic [DATA_W+chk_bits(DATA_W):0] word_in,
   input  logic                             out_ce,
   input  logic                             out_srst,
   output logic [DATA_W-1:0]                rd_data,
   output logic                             err_corr,
   output logic                             err_uncorr
);
   localparam int CW_W = DATA_W + chk_bits(DATA_W) + 1;

   logic [CW_W-1:0]   raw_q;
   logic              ecc_q;
   logic [DATA_W-1:0] dec_data;
   logic              dec_corr;
   logic              dec_uncorr;

   // capture stage: loaded only on a read, so rd_en low freezes the path
   always_ff @(posedge clk) begin
      if (rd_en) begin
         raw_q <= word_in;
         ecc_q <= ecc_on;
      end
   end

   ecc_bram_dec #(.DATA_W(DATA_W)) u_dec (
      .cw     (raw_q),
      .ecc_on (ecc_q),
      .dout   (dec_data),
      .corr   (dec_corr),
      .uncorr (dec_uncorr)
   );

   always_ff @(posedge clk) begin
      if (out_srst) begin
         rd_data    <= '0;
         err_corr   <= 1'b0;
         err_uncorr <= 1'b0;
      end else if (out_ce) begin
         rd_data    <= dec_data;
         err_corr   <= dec_corr;
         err_uncorr <= dec_uncorr;
      end
   end
endmodule

// File: rtl/ecc_bram.sv
module ecc_bram
   import ecc_bram_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   localparam int CW_W  = DATA_W + chk_bits(DATA_W) + 1,
   localparam int AW    = $clog2(DEPTH),
   localparam int NB    = DATA_W / 8,
   localparam int IBW   = $clog2(CW_W)
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [NB-1:0]     wr_be,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ecc_on,
   input  logic              zero_go,
   output logic              zero_busy,
   input  logic              inj_en,
   input  logic [AW-1:0]     inj_addr,
   input  logic [IBW-1:0]    inj_bit,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   input  logic              out_ce,
   input  logic              out_srst,
   output logic [DATA_W-1:0] rd_data,
   output logic              err_corr,
   output logic              err_uncorr
);
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("ecc_bram: DATA_W must be a nonzero multiple of 8");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("ecc_bram: DEPTH must be a power of two, at least 2");
   end

   logic [AW-1:0]   zero_addr;
   logic [CW_W-1:0] rd_word;

   ecc_bram_zero #(.DEPTH(DEPTH), .AW(AW)) u_zero (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .go    (zero_go),
      .busy  (zero_busy),
      .addr  (zero_addr)
   );

   ecc_bram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .IBW(IBW)) u_array (
      .clk       (wr_clk),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_be     (wr_be),
      .wr_data   (wr_data),
      .ecc_on    (ecc_on),
      .zero_busy (zero_busy),
      .zero_addr (zero_addr),
      .inj_en    (inj_en),
      .inj_addr  (inj_addr),
      .inj_bit   (inj_bit),
      .rd_addr   (rd_addr),
      .rd_word   (rd_word)
   );

   ecc_bram_rdpath #(.DATA_W(DATA_W)) u_rd (
      .clk        (rd_clk),
      .rd_en      (rd_en),
      .ecc_on     (ecc_on),
      .word_in    (rd_word),
      .out_ce     (out_ce),
      .out_srst   (out_srst),
      .rd_data    (rd_data),
      .err_corr   (err_corr),
      .err_uncorr (err_uncorr)
   );
endmodule

// File: rtl/ecc_bram_chk.sv
module ecc_bram_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              ecc_on,
   input logic              out_ce,
   input logic              out_srst,
   input logic              zero_go,
   input logic              zero_busy,
   input logic [DATA_W-1:0] rd_data,
   input logic              err_corr,
   input logic              err_uncorr
);
   localparam int CW = $clog2(DEPTH) + 2;
   logic [CW-1:0] busy_run;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n)         busy_run <= '0;
      else if (zero_busy) busy_run <= busy_run + 1'b1;
      else                busy_run <= '0;
   end

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !(err_corr && err_uncorr)); // R4

   AST_SRST_CLEARS: assert property (@(posedge rd_clk) disable iff (!rst_n)
      out_srst |=> (rd_data == '0) && !err_corr && !err_uncorr); // R7

   AST_CE_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!out_ce && !out_srst) |=> $stable(rd_data)); // R7

   AST_RDEN_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!rd_en && out_ce && !out_srst && $past(!rd_en && out_ce && !out_srst))
      |=> $stable(rd_data)); // R6

   AST_BYPASS_NO_FLAGS: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_en && !ecc_on) ##1 (out_ce && !out_srst) |=> (!err_corr && !err_uncorr)); // R5

   AST_ZERO_START: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (zero_go && !zero_busy) |=> zero_busy); // R10

   AST_ZERO_LENGTH: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $fell(zero_busy) |-> (int'(busy_run) == DEPTH)); // R10
endmodule

bind ecc_bram ecc_bram_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .wr_clk     (wr_clk),
   .rd_clk     (rd_clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .ecc_on     (ecc_on),
   .out_ce     (out_ce),
   .out_srst   (out_srst),
   .zero_go    (zero_go),
   .zero_busy  (zero_busy),
   .rd_data    (rd_data),
   .err_corr   (err_corr),
   .err_uncorr (err_uncorr)
);

// File: tb/ecc_bram_tb_top.sv
`timescale 1ns/1ps
module ecc_bram_tb_top;
   localparam int DW = 32;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] wr_data = '0;
   logic        ecc_on = 1'b1;
   logic        zero_go = 1'b0;
   logic        zero_busy;
   logic        inj_en = 1'b0;
   logic [5:0]  inj_addr = '0;
   logic [5:0]  inj_bit = '0;
   logic        rd_en = 1'b0;
   logic [5:0]  rd_addr = '0;
   logic        out_ce = 1'b1;
   logic        out_srst = 1'b1;
   logic [31:0] rd_data;
   logic        err_corr;
   logic        err_uncorr;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] got_d;
   logic        got_s, got_u;

   always #2.5 clk = ~clk;

   ecc_bram #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
      .ecc_on(ecc_on), .zero_go(zero_go), .zero_busy(zero_busy),
      .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
      .rd_en(rd_en), .rd_addr(rd_addr), .out_ce(out_ce), .out_srst(out_srst),
      .rd_data(rd_data), .err_corr(err_corr), .err_uncorr(err_uncorr)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic inject(input logic [5:0] a, input logic [5:0] b);
      @(negedge clk);
      inj_en = 1'b1; inj_addr = a; inj_bit = b;
      @(negedge clk);
      inj_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
      got_d = rd_data; got_s = err_corr; got_u = err_uncorr;
   endtask

   task automatic rd_expect(input string req, input logic [5:0] a, input logic [31:0] d,
                            input logic s, input logic u);
      rd(a);
      chk(req, {got_d, 1'b0, got_s, 1'b0, got_u}, {d, 1'b0, s, 1'b0, u});
   endtask

   task automatic t_reset;
      repeat (4) @(negedge clk);
      chk("R10 busy idle after reset", 64'(zero_busy), 64'd0);
      chk("R7 cleared output at reset", {rd_data, 1'b0, err_corr, 1'b0, err_uncorr}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      out_srst = 1'b0;
   endtask

   task automatic t_zeroize;
      int cnt;
      @(negedge clk); zero_go = 1'b1;
      @(negedge clk); zero_go = 1'b0;
      cnt = 0;
      while (zero_busy && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      chk("R10 busy length", 64'(cnt), 64'(DEPTH));
      rd_expect("R10 word 0 cleared", 6'd0, 32'h0, 1'b0, 1'b0);
      rd_expect("R10 word 33 cleared", 6'd33, 32'h0, 1'b0, 1'b0);
      rd_expect("R10 word 63 cleared", 6'd63, 32'h0, 1'b0, 1'b0);
   endtask

   task automatic t_basic;
      wr(6'd1, 32'hA5A5_5A5A, 4'hF);
      rd_expect("R2 word 1", 6'd1, 32'hA5A5_5A5A, 1'b0, 1'b0);
      wr(6'd2, 32'hFFFF_FFFF, 4'hF);
      wr(6'd3, 32'h8000_0001, 4'hF);
      rd_expect("R2 word 2", 6'd2, 32'hFFFF_FFFF, 1'b0, 1'b0);
      rd_expect("R2 word 3", 6'd3, 32'h8000_0001, 1'b0, 1'b0);
      // R12: write edge followed by read capture one cycle later
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd4; wr_data = 32'h1357_9BDF; wr_be = 4'hF;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b1; rd_addr = 6'd4;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
      chk("R12 read after write", 64'(rd_data), 64'h1357_9BDF);
   endtask

   task automatic t_bytes;
      wr(6'd10, 32'h1122_3344, 4'hF);
      wr(6'd10, 32'hAABB_CCDD, 4'b0101);
      rd_expect("R8 lanes 0 and 2", 6'd10, 32'h11BB_33DD, 1'b0, 1'b0);
      wr(6'd10, 32'h9900_0000, 4'b1000);
      rd_expect("R8 lane 3", 6'd10, 32'h99BB_33DD, 1'b0, 1'b0);
      wr(6'd10, 32'hFFFF_FFFF, 4'b0000);
      rd_expect("R8 no lanes", 6'd10, 32'h99BB_33DD, 1'b0, 1'b0);
   endtask

   task automatic t_single;
      logic [5:0] bits [4] = '{6'd0, 6'd2, 6'd37, 6'd38};
      for (int i = 0; i < 4; i++) begin
         wr(6'(40 + i), 32'hC0DE_0000 | 32'(i), 4'hF);
         inject(6'(40 + i), bits[i]);
         rd_expect("R3 single corrected (R1 layout)", 6'(40 + i), 32'hC0DE_0000 | 32'(i), 1'b1, 1'b0);
      end
   endtask

   task automatic t_bypass_double;
      wr(6'd30, 32'h0F0F_0F0F, 4'hF);
      inject(6'd30, 6'd2);
      @(negedge clk); ecc_on = 1'b0;
      rd_expect("R5 raw bit 0 (R1 stored bit 2)", 6'd30, 32'h0F0F_0F0E, 1'b0, 1'b0);
      inject(6'd30, 6'd37);
      rd_expect("R5 raw bit 31 (R1 stored bit 37)", 6'd30, 32'h8F0F_0F0E, 1'b0, 1'b0);
      @(negedge clk); ecc_on = 1'b1;
      rd(6'd30);
      chk("R4 double detected", {62'd0, got_s, got_u}, 64'd1);
   endtask

   task automatic t_rmw;
      wr(6'd20, 32'h1122_3344, 4'hF);
      inject(6'd20, 6'd12);      // data bit 8 per R1
      wr(6'd20, 32'h0000_00AA, 4'b0001);
      rd_expect("R9 merged and clean", 6'd20, 32'h1122_33AA, 1'b0, 1'b0);
      @(negedge clk); ecc_on = 1'b0;
      rd_expect("R9 stored bits repaired", 6'd20, 32'h1122_33AA, 1'b0, 1'b0);
      @(negedge clk); ecc_on = 1'b1;
   endtask

   task automatic t_hold_rden;
      wr(6'd7, 32'hAAAA_0007, 4'hF);
      rd_expect("R2 word 7", 6'd7, 32'hAAAA_0007, 1'b0, 1'b0);
      wr(6'd7, 32'hBBBB_0007, 4'hF);
      rd_addr = 6'd7;
      repeat (3) @(negedge clk);
      chk("R6 hold with rd_en low", 64'(rd_data), 64'hAAAA_0007);
   endtask

   task automatic t_outreg;
      @(negedge clk); out_ce = 1'b0;
      rd(6'd1);
      chk("R7 hold with out_ce low", 64'(got_d), 64'hAAAA_0007);
      @(negedge clk); out_ce = 1'b1;
      @(negedge clk);
      chk("R7 load after out_ce high", 64'(rd_data), 64'hA5A5_5A5A);
      out_ce = 1'b0; out_srst = 1'b1;
      @(negedge clk);
      out_srst = 1'b0;
      chk("R7 clear beats out_ce", {rd_data, 1'b0, err_corr, 1'b0, err_uncorr}, 64'd0);
      out_ce = 1'b1;
   endtask

   task automatic t_inject_vs_write;
      wr(6'd50, 32'h5555_AAAA, 4'hF);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd51; wr_data = 32'h0; wr_be = 4'hF;
      inj_en = 1'b1; inj_addr = 6'd50; inj_bit = 6'd5;
      @(negedge clk);
      wr_en = 1'b0; inj_en = 1'b0;
      rd_expect("R13 injection ignored with write", 6'd50, 32'h5555_AAAA, 1'b0, 1'b0);
   endtask

   task automatic t_zero_lockout;
      wr(6'd0, 32'h1234_5678, 4'hF);
      @(negedge clk); zero_go = 1'b1;
      @(negedge clk); zero_go = 1'b0;
      repeat (10) @(negedge clk);
      wr(6'd0, 32'hDEAD_BEEF, 4'hF);
      inject(6'd1, 6'd4);
      @(negedge clk); zero_go = 1'b1;
      @(negedge clk); zero_go = 1'b0;
      for (int i = 0; i < 200 && zero_busy; i++) @(negedge clk);
      chk("R11 sweep not restarted", 64'(zero_busy), 64'd0);
      rd_expect("R11 write ignored", 6'd0, 32'h0, 1'b0, 1'b0);
      rd_expect("R11 inject ignored", 6'd1, 32'h0, 1'b0, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_zeroize();
      t_basic();
      t_bytes();
      t_single();
      t_bypass_double();
      t_rmw();
      t_hold_rden();
      t_outreg();
      t_inject_vs_write();
      t_zero_lockout();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule